// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim/Complete

This block collects interrupt requests from up to a parameterised number of sources and presents them to several hart contexts. Each context has one interrupt output. Each source has a 3-bit priority. Each context has a bitmap that selects the sources it takes, and a threshold. A context's output rises only when at least one source meets three conditions: it is pending, it is enabled for that context, and its priority is strictly above that context's threshold.

Software services an interrupt in two steps on one register per context. First it reads that register. The read returns the ID of the best eligible source and removes that source from the pending set. From then on the source is in flight and raises no new request. Software then writes the same ID back to the register. This completes the source and re-arms it. Each source can be set to sample its input as a level or as a rising edge. An edge source that pulses while in flight keeps one further request and presents it after completion.

The register port is a plain address/data port with no handshake. It never stalls. Writes take effect at the clock edge where the write enable is high. Read data appears on `rdata_o` one cycle after the read enable and holds until the next read. Source inputs are synchronous to `clk_i`. There is no stream interface, so there is no back-pressure.

Top module: `pic_claim_ctrl`

## Requirements
- R1: Source IDs run from 1 to NUM_SRC, and ID 0 means "none". Reading a claim register when the context has no eligible source returns 0 and changes no state.
- R2: The priority of source k is at byte address 4*k and holds 3 bits. Unused upper bits read as zero, and writes to address 0 (source 0) are ignored.
- R3: The enable bitmap of context c starts at 0x2000 + 0x80*c. Source k is bit k%32 of the word at offset 4*(k/32), and the bits read back as written.
- R4: A source whose priority is 0 never raises an interrupt.
- R5: irq_o[c] is 1 exactly when some pending source enabled for c has priority strictly greater than c's threshold. A threshold of 7 masks the context completely.
- R6: A read of context c's claim register returns the best eligible source ID and clears that source's pending state in the same cycle.
- R7: Among eligible sources the highest priority wins, and equal priorities go to the lowest ID.
- R8: Writing an ID to context c's claim register completes that source. The write is ignored if the ID is 0, above NUM_SRC, or not enabled for c, and a source stays blocked until it is completed.
- R9: The trigger-mode bitmap at 0x1000 marks source k at bit k%32 of the word at offset 4*(k/32). A 1 selects rising-edge mode and a 0 selects level-high mode. In edge mode a rising edge sets pending, and at most one edge during the in-flight window is kept and presented at completion.
- R10: A level source is re-sampled on the cycle after its completion.
- R11: Reset clears all priorities, enables, trigger modes, thresholds, pending and in-flight state, and the read data.
- R12: The threshold of context c is at 0x200000 + 0x1000*c, and its claim/complete register is at that address + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (a claim read has side effects) |
| rdata_o | output | 32 | Read data, valid the cycle after re_i |
| src_i | input | NUM_SRC | Source request lines, bit k is source k |
| irq_o | output | NUM_CTX | Per-context interrupt request |

## Verification
The bound assertions check four properties on every cycle:
- at most one source is claimed per cycle;
- a claimed source is no longer pending on the next cycle;
- claim read data never exceeds NUM_SRC;
- no context raises its output while nothing is pending or every priority is zero.

The bench scenarios cover what those properties cannot express:
- the priority/ID tie order;
- strict threshold comparison;
- ignored completions;
- the single held edge during the in-flight window;
- level re-sampling after completion;
- the address map read-back.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;
  localparam int TRIG_BASE  = 'h1000;
  localparam int EN_BASE    = 'h2000;
  localparam int EN_STRIDE  = 'h80;
  localparam int CTX_BASE   = 'h200000;
  localparam int CTX_STRIDE = 'h1000;
  localparam int CLAIM_OFS  = 4;

  function automatic int words_for(int nsrc);
    return (nsrc + 32) / 32;
  endfunction
endpackage

// File: rtl/pcc_gateway.sv
`timescale 1ns/1ps
module pcc_gateway (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic edge_mode_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o
);
  logic prev_q, pend_q, busy_q, held_q;
  logic rise;

  assign rise      = src_i & ~prev_q;
  assign pending_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      prev_q <= src_i;
      if (claim_i) begin
        pend_q <= 1'b0;
        busy_q <= 1'b1;
        held_q <= 1'b0;
      end else if (busy_q) begin
        if (complete_i) begin
          busy_q <= 1'b0;
          pend_q <= edge_mode_i & (held_q | rise);
          held_q <= 1'b0;
        end else if (edge_mode_i && rise) begin
          held_q <= 1'b1;
        end
      end else begin
        pend_q <= edge_mode_i ? (pend_q | rise) : src_i;
      end
    end
  end
endmodule

// File: rtl/pcc_arbiter.sv
`timescale 1ns/1ps
module pcc_arbiter #(
  parameter int NUM_SRC = 31,
  parameter int PW      = 3,
  parameter int IDW     = 5
) (
  input  logic [NUM_SRC:0]         elig_i,
  input  logic [NUM_SRC:0][PW-1:0] prio_i,
  input  logic [PW-1:0]            thr_i,
  output logic [IDW-1:0]           id_o,
  output logic                     irq_o
);
  logic [PW-1:0]  best_p;
  logic [IDW-1:0] best_id;

  always_comb begin
    best_p  = '0;
    best_id = '0;
    for (int k = 0; k <= NUM_SRC; k++) begin
      if (elig_i[k] && (prio_i[k] > best_p)) begin
        best_p  = prio_i[k];
        best_id = IDW'(k);
      end
    end
    irq_o = (best_p > thr_i);
    id_o  = irq_o ? best_id : '0;
  end
endmodule

// File: rtl/pic_claim_ctrl.sv
`timescale 1ns/1ps
module pic_claim_ctrl
  import pcc_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PW      = 3,
  parameter int ADDR_W  = 26
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC:1]   src_i,
  output logic [NUM_CTX-1:0] irq_o
);
  localparam int IDW = $clog2(NUM_SRC + 1);
  localparam int NW  = words_for(NUM_SRC);

  logic [NUM_SRC:0][PW-1:0]  prio_q;
  logic [NUM_SRC:0]          trig_q;
  logic [NUM_CTX-1:0][NUM_SRC:0] en_q;
  logic [NUM_CTX-1:0][PW-1:0]    thr_q;
  logic [31:0]               rdata_q;

  logic [NUM_SRC:0]          pend;
  logic [NUM_SRC:1]          claim_vec;
  logic [NUM_SRC:1]          cmpl_vec;
  logic [NUM_CTX-1:0][IDW-1:0] best_id;

  // address decode
  logic aligned, is_prio, is_trig;
  int   sid, trig_word, en_word;
  logic [NUM_CTX-1:0] en_hit, thr_hit, clm_hit;

  always_comb begin
    aligned   = (addr_i[1:0] == 2'b00);
    is_prio   = aligned && (addr_i < ADDR_W'(TRIG_BASE));
    sid       = int'(addr_i[ADDR_W-1:2]);
    is_trig   = aligned && (addr_i >= ADDR_W'(TRIG_BASE)) &&
                (addr_i < ADDR_W'(TRIG_BASE + 4*NW));
    trig_word = (int'(addr_i) - TRIG_BASE) / 4;
    en_hit    = '0;
    thr_hit   = '0;
    clm_hit   = '0;
    en_word   = 0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (aligned && (addr_i >= ADDR_W'(EN_BASE + c*EN_STRIDE)) &&
          (addr_i < ADDR_W'(EN_BASE + c*EN_STRIDE + 4*NW))) begin
        en_hit[c] = 1'b1;
        en_word   = (int'(addr_i) - EN_BASE - c*EN_STRIDE) / 4;
      end
      thr_hit[c] = (addr_i == ADDR_W'(CTX_BASE + c*CTX_STRIDE));
      clm_hit[c] = (addr_i == ADDR_W'(CTX_BASE + c*CTX_STRIDE + CLAIM_OFS));
    end
  end

  // claim and completion
  logic           rd_claim;
  logic [IDW-1:0] sel_id;

  always_comb begin
    sel_id = '0;
    for (int c = 0; c < NUM_CTX; c++)
      if (clm_hit[c]) sel_id = best_id[c];
  end

  assign rd_claim = re_i && (|clm_hit);

  always_comb begin
    claim_vec = '0;
    cmpl_vec  = '0;
    for (int k = 1; k <= NUM_SRC; k++) begin
      claim_vec[k] = rd_claim && (sel_id == IDW'(k));
      for (int c = 0; c < NUM_CTX; c++)
        if (we_i && clm_hit[c] && (wdata_i == 32'(k)) && en_q[c][k])
          cmpl_vec[k] = 1'b1;
    end
  end

  // read mux
  logic [31:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (is_prio)
      for (int k = 0; k <= NUM_SRC; k++)
        if (sid == k) rd_val = 32'(prio_q[k]);
    if (is_trig)
      for (int k = 0; k <= NUM_SRC; k++)
        if (k / 32 == trig_word) rd_val[k % 32] = trig_q[k];
    for (int c = 0; c < NUM_CTX; c++) begin
      if (en_hit[c])
        for (int k = 0; k <= NUM_SRC; k++)
          if (k / 32 == en_word) rd_val[k % 32] = en_q[c][k];
      if (thr_hit[c]) rd_val = 32'(thr_q[c]);
      if (clm_hit[c]) rd_val = 32'(best_id[c]);
    end
  end

  // register file
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q  <= '0;
      trig_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (re_i) rdata_q <= rd_val;
      if (we_i) begin
        for (int k = 1; k <= NUM_SRC; k++) begin
          if (is_prio && (sid == k)) prio_q[k] <= wdata_i[PW-1:0];
          if (is_trig && (trig_word == k / 32)) trig_q[k] <= wdata_i[k % 32];
        end
        for (int c = 0; c < NUM_CTX; c++) begin
          for (int k = 1; k <= NUM_SRC; k++)
            if (en_hit[c] && (en_word == k / 32)) en_q[c][k] <= wdata_i[k % 32];
          if (thr_hit[c]) thr_q[c] <= wdata_i[PW-1:0];
        end
      end
    end
  end

  assign rdata_o = rdata_q;

  // per-source gateways
  assign pend[0] = 1'b0;
  for (genvar k = 1; k <= NUM_SRC; k++) begin : g_src
    pcc_gateway u_gw (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i[k]),
      .edge_mode_i(trig_q[k]),
      .claim_i    (claim_vec[k]),
      .complete_i (cmpl_vec[k]),
      .pending_o  (pend[k])
    );
  end

  // per-context arbiters
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic [NUM_SRC:0] elig;
    assign elig = pend & en_q[c];
    pcc_arbiter #(.NUM_SRC(NUM_SRC), .PW(PW), .IDW(IDW)) u_arb (
      .elig_i(elig),
      .prio_i(prio_q),
      .thr_i (thr_q[c]),
      .id_o  (best_id[c]),
      .irq_o (irq_o[c])
    );
  end
endmodule

// File: rtl/pcc_checker.sv
`timescale 1ns/1ps
module pcc_checker #(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PW      = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_SRC:0]         pend_i,
  input logic [NUM_SRC:1]         claim_i,
  input logic [NUM_SRC:0][PW-1:0] prio_i,
  input logic [NUM_CTX-1:0]       irq_i,
  input logic                     rd_claim_i,
  input logic [31:0]              rdata_i
);
  // R6: at most one source granted per cycle
  a_r6_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_i));

  // R6: a granted source is no longer pending afterwards
  a_r6_claim_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|claim_i) |=> ((pend_i[NUM_SRC:1] & $past(claim_i)) == '0));

  // R1: claim data is 0 or a valid source ID
  a_r1_id_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_claim_i |=> (rdata_i <= 32'(NUM_SRC)));

  // R5: no request without a pending source
  a_r5_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_i) |-> (|pend_i));

  // R4: all priorities zero keeps every context quiet
  a_r4_zero_prio_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_i == '0) |-> (irq_i == '0));
endmodule

bind pic_claim_ctrl pcc_checker #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PW(PW)
) u_pcc_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pend_i    (pend),
  .claim_i   (claim_vec),
  .prio_i    (prio_q),
  .irq_i     (irq_o),
  .rd_claim_i(rd_claim),
  .rdata_i   (rdata_o)
);

// File: tb/pic_claim_ctrl_test.sv
`timescale 1ns/1ps
module pic_claim_ctrl_test;
  localparam int NSRC = 31;
  localparam int NCTX = 2;
  localparam int AW   = 26;

  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  localparam logic [AW-1:0] TRG = 26'h1000, EN0 = 26'h2000, EN1 = 26'h2080;
  localparam logic [AW-1:0] TH0 = 26'h200000, CL0 = 26'h200004;
  localparam logic [AW-1:0] TH1 = 26'h201000, CL1 = 26'h201004;
  localparam logic [31:0] S357 = 32'hA8, S3 = 32'h8, S5 = 32'h20, S0 = 32'h0;

  typedef struct packed {
    logic [1:0]    op;
    logic [31:0]   src;
    logic [AW-1:0] addr;
    logic [31:0]   data;
    logic [31:0]   exp;
    logic [1:0]    irq;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 48;
  localparam vec_t VEC [NV] = '{
    '{OP_WR,   S0,   26'hC,  32'd5,        32'd0,    2'b00, 8'd2},  // R2
    '{OP_WR,   S0,   26'h14, 32'd5,        32'd0,    2'b00, 8'd2},
    '{OP_WR,   S0,   26'h1C, 32'd2,        32'd0,    2'b00, 8'd2},
    '{OP_WR,   S0,   EN0,    32'hA8,       32'd0,    2'b00, 8'd3},  // R3
    '{OP_RD,   S0,   26'hC,  32'd0,        32'd5,    2'b00, 8'd2},
    '{OP_WR,   S0,   26'hC,  32'hFFFFFFFD, 32'd0,    2'b00, 8'd2},
    '{OP_RD,   S0,   26'hC,  32'd0,        32'd5,    2'b00, 8'd2},  // R2 upper bits zero
    '{OP_WR,   S0,   26'h0,  32'd7,        32'd0,    2'b00, 8'd2},
    '{OP_RD,   S0,   26'h0,  32'd0,        32'd0,    2'b00, 8'd2},  // R2 source 0 ignored
    '{OP_IDLE, S357, 26'h0,  32'd0,        32'd0,    2'b01, 8'd5},  // R5
    '{OP_RD,   S357, CL0,    32'd0,        32'd3,    2'b01, 8'd7},  // R7 tie -> lowest ID
    '{OP_RD,   S357, CL0,    32'd0,        32'd5,    2'b01, 8'd6},  // R6
    '{OP_WR,   S357, TH0,    32'd2,        32'd0,    2'b00, 8'd5},  // R5 strict compare
    '{OP_RD,   S357, CL0,    32'd0,        32'd0,    2'b00, 8'd1},  // R1 nothing eligible
    '{OP_WR,   S357, TH0,    32'd0,        32'd0,    2'b01, 8'd12}, // R12
    '{OP_RD,   S357, CL0,    32'd0,        32'd7,    2'b00, 8'd6},
    '{OP_WR,   S357, CL0,    32'd9,        32'd0,    2'b00, 8'd8},  // R8 not enabled
    '{OP_WR,   S357, CL1,    32'd3,        32'd0,    2'b00, 8'd8},  // R8 wrong context
    '{OP_IDLE, S357, 26'h0,  32'd0,        32'd0,    2'b00, 8'd8},  // R8 still blocked
    '{OP_WR,   S357, CL0,    32'd3,        32'd0,    2'b00, 8'd10}, // R10
    '{OP_IDLE, S357, 26'h0,  32'd0,        32'd0,    2'b01, 8'd10}, // R10 re-sampled
    '{OP_RD,   S357, CL0,    32'd0,        32'd3,    2'b00, 8'd6},
    '{OP_WR,   S0,   CL0,    32'd3,        32'd0,    2'b00, 8'd8},
    '{OP_WR,   S0,   CL0,    32'd5,        32'd0,    2'b00, 8'd8},
    '{OP_WR,   S0,   CL0,    32'd7,        32'd0,    2'b00, 8'd8},
    '{OP_WR,   S0,   TRG,    32'h8,        32'd0,    2'b00, 8'd9},  // R9
    '{OP_RD,   S0,   TRG,    32'd0,        32'h8,    2'b00, 8'd9},
    '{OP_IDLE, S3,   26'h0,  32'd0,        32'd0,    2'b01, 8'd9},
    '{OP_IDLE, S0,   26'h0,  32'd0,        32'd0,    2'b01, 8'd9},  // edge latched
    '{OP_RD,   S0,   CL0,    32'd0,        32'd3,    2'b00, 8'd9},
    '{OP_IDLE, S3,   26'h0,  32'd0,        32'd0,    2'b00, 8'd9},
    '{OP_IDLE, S0,   26'h0,  32'd0,        32'd0,    2'b00, 8'd9},
    '{OP_IDLE, S3,   26'h0,  32'd0,        32'd0,    2'b00, 8'd9},
    '{OP_WR,   S3,   CL0,    32'd3,        32'd0,    2'b01, 8'd9},  // held edge shown
    '{OP_RD,   S3,   CL0,    32'd0,        32'd3,    2'b00, 8'd9},
    '{OP_WR,   S3,   CL0,    32'd3,        32'd0,    2'b00, 8'd9},  // only one held
    '{OP_RD,   S3,   CL0,    32'd0,        32'd0,    2'b00, 8'd1},
    '{OP_WR,   S5,   EN1,    32'h20,       32'd0,    2'b11, 8'd3},
    '{OP_WR,   S5,   TH1,    32'd7,        32'd0,    2'b01, 8'd5},  // R5 full mask
    '{OP_RD,   S5,   CL1,    32'd0,        32'd0,    2'b01, 8'd5},
    '{OP_RD,   S5,   CL0,    32'd0,        32'd5,    2'b00, 8'd6},
    '{OP_WR,   S5,   CL1,    32'd5,        32'd0,    2'b00, 8'd8},  // R8 other enabled ctx
    '{OP_IDLE, S5,   26'h0,  32'd0,        32'd0,    2'b01, 8'd10},
    '{OP_WR,   S5,   26'h14, 32'd0,        32'd0,    2'b00, 8'd4},  // R4
    '{OP_WR,   S5,   CL0,    32'd40,       32'd0,    2'b00, 8'd8},  // R8 out of range
    '{OP_RD,   S5,   EN0,    32'd0,        32'hA8,   2'b00, 8'd3},
    '{OP_RD,   S5,   TH1,    32'd0,        32'd7,    2'b00, 8'd12},
    '{OP_RD,   S5,   EN1,    32'd0,        32'h20,   2'b00, 8'd3}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic            we = 1'b0, re = 1'b0;
  logic [31:0]     rdata;
  logic [NSRC:1]   src = '0;
  logic [NCTX-1:0] irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pic_claim_ctrl #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .PW(3), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  task automatic check32(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [AW-1:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    we    = (op == OP_WR);
    re    = (op == OP_RD);
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    re = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check32(11, 32'(irq), 32'd0);
    check32(11, rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      src = VEC[i].src[NSRC:1];
      apply(VEC[i].op, VEC[i].addr, VEC[i].data);
      if (VEC[i].op == OP_RD) check32(int'(VEC[i].req), rdata, VEC[i].exp);
      check32(int'(VEC[i].req), 32'(irq), 32'(VEC[i].irq));
    end
    // R11: mid-run reset clears configuration and requests
    src = S357[NSRC:1];
    apply(OP_WR, 26'h14, 32'd6);
    rst_n = 1'b0;
    #1;
    check32(11, 32'(irq), 32'd0);
    @(negedge clk);
    check32(11, rdata, 32'd0);
    rst_n = 1'b1;
    src = '0;
    @(negedge clk);
    apply(OP_RD, 26'h14, 32'd0);
    check32(11, rdata, 32'd0);
    apply(OP_RD, EN0, 32'd0);
    check32(11, rdata, 32'd0);
    apply(OP_RD, TH1, 32'd0);
    check32(11, rdata, 32'd0);
    apply(OP_RD, TRG, 32'd0);
    check32(11, rdata, 32'd0);
    apply(OP_RD, CL0, 32'd0);
    check32(1, rdata, 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule